// File: doc/BRIEF.md
# Priority-Encoded Pin Function Multiplexer

This block decides, for every pin of one 32-pin bank, which of six sources owns the pad: the GPIO bank or one of five peripheral functions. Each peripheral function has its own one-bit-per-pin claim mask, held in a small register file. When more than one mask claims the same pin, a fixed priority picks the owner. A pin that no mask claims goes back to GPIO. A separate pull-up mask sits in the same register space and drives a per-pin pull-up request.

The owner's output value and output enable are routed to the pad. Sources that do not own the pin have no effect on it, so handing a pin to a peripheral takes it away from GPIO without any extra disable step. The pad input is fanned out unchanged to every source. Each claim mask can be written directly, or updated through write-one-to-set and write-one-to-clear aliases, so that software can move a single pin without a read-modify-write. A packed per-pin status port reports the function code currently in force.

Top module: `pinmux_bank`

## Requirements
- R1: After reset all six mask registers read zero, every pin's function code is 0 and the pad output and output enable equal the GPIO output and output enable.
- R2: A write with access bits reg_addr[9:8]=00 replaces the addressed mask. The claim masks are at offsets reg_addr[7:0] 0x14 (function 1), 0x8C (function 2), 0x94 (function 3), 0x9C (function 4) and 0xA4 (function 5), and bit i belongs to pin i. A read at access bits 00, 01 or 10 returns the mask at that offset.
- R3: A write with access bits 01 ORs the write data into the addressed mask and leaves bits written as 0 unchanged.
- R4: A write with access bits 10 clears the mask bits where the write data is 1 and leaves the others unchanged.
- R5: When several masks claim one pin, the lowest function number wins: 1 before 2 before 3 before 4 before 5.
- R6: A pin claimed by no mask has function code 0 and takes its pad output and output enable from the GPIO inputs.
- R7: A pin owned by function k takes its pad output and output enable from that function's bits (bus slice [(k-1)*32 +: 32]). GPIO and the other functions do not affect that pin.
- R8: gpio_in equals pad_in, and every 32-bit slice of func_in equals pad_in, whatever the function selection.
- R9: pin_code[3*i+2:3*i] holds pin i's function code: 0 for GPIO and 1 to 5 for the owning function.
- R10: The pull-up mask at offset 0xAC supports the same write, set and clear access as the claim masks and drives pad_pull_up bit for bit. It has no effect on function selection.
- R11: Writes with access bits 11, or to an offset that is not a mask, change no register. Reads with access bits 11, or from such an offset, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 10 | Access bits [9:8] and register offset [7:0] |
| reg_wdata | input | 32 | Write data, one bit per pin |
| reg_rdata | output | 32 | Read data for reg_addr |
| gpio_out | input | 32 | GPIO bank output values |
| gpio_oe | input | 32 | GPIO bank output enables |
| gpio_in | output | 32 | Pad input returned to the GPIO bank |
| func_out | input | 160 | Output values of functions 1..5, 32 bits each |
| func_oe | input | 160 | Output enables of functions 1..5, 32 bits each |
| func_in | output | 160 | Pad input copied to each function |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |
| pad_in | input | 32 | Pad input values |
| pad_pull_up | output | 32 | Per-pin pull-up request |
| pin_code | output | 96 | Per-pin 3-bit function code |

## Verification
The hardest case to reach is a single pin claimed by all five masks at once, with ownership then passing down the priority ladder one step at a time. The stimulus builds this state with set-alias writes to bit 31 of every claim mask, which leaves the other pins alone. It then removes the claims one by one with clear-alias writes, in priority order. After each step it checks the code and the pad routing of pin 31 and of its neighbours, until the pin falls back to GPIO. Distinct bit patterns on every source make a wrong owner show up at the pad.

// File: rtl/pinmux_pkg.sv
package pinmux_pkg;
   localparam int NUM_SEL  = 5;
   localparam int OFS_W    = 8;
   localparam int ACC_W    = 2;

   typedef enum logic [ACC_W-1:0] {
      ACC_WRITE = 2'b00,
      ACC_SET   = 2'b01,
      ACC_CLEAR = 2'b10,
      ACC_NONE  = 2'b11
   } acc_mode_e;

   // register index 0..NUM_SEL-1 are claim masks in priority order, NUM_SEL is pull-up
   function automatic logic [OFS_W-1:0] reg_offset(int idx);
      case (idx)
         0:       return 8'h14;
         1:       return 8'h8C;
         2:       return 8'h94;
         3:       return 8'h9C;
         4:       return 8'hA4;
         default: return 8'hAC;
      endcase
   endfunction
endpackage

// File: rtl/pinmux_sel_regs.sv
module pinmux_sel_regs
   import pinmux_pkg::*;
#(
   parameter int NUM_PINS  = 32,
   parameter int NUM_FUNCS = 5,
   parameter int ADDR_W    = 10
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic [ADDR_W-1:0]                  addr,
   input  logic [NUM_PINS-1:0]                wdata,
   output logic [NUM_PINS-1:0]                rdata,
   output logic [NUM_FUNCS-1:0][NUM_PINS-1:0] sel_mask,
   output logic [NUM_PINS-1:0]                pull_mask
);
   localparam int NUM_REGS = NUM_FUNCS + 1;

   logic [NUM_REGS-1:0][NUM_PINS-1:0] regs_q;
   logic [NUM_REGS-1:0]               hit;
   acc_mode_e                         mode;
   logic [OFS_W-1:0]                  ofs;

   assign mode = acc_mode_e'(addr[ADDR_W-1 -: ACC_W]);
   assign ofs  = addr[OFS_W-1:0];

   always_comb begin
      for (int r = 0; r < NUM_REGS; r++)
         hit[r] = (ofs == reg_offset(r)) && (mode != ACC_NONE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         regs_q <= '0;
      end else if (wr_en) begin
         for (int r = 0; r < NUM_REGS; r++) begin
            if (hit[r]) begin
               case (mode)
                  ACC_WRITE: regs_q[r] <= wdata;
                  ACC_SET:   regs_q[r] <= regs_q[r] | wdata;
                  ACC_CLEAR: regs_q[r] <= regs_q[r] & ~wdata;
                  default:   ;
               endcase
            end
         end
      end
   end

   always_comb begin
      rdata = '0;
      for (int r = 0; r < NUM_REGS; r++)
         if (hit[r]) rdata = rdata | regs_q[r];
   end

   assign sel_mask  = regs_q[NUM_FUNCS-1:0];
   assign pull_mask = regs_q[NUM_FUNCS];

   for (genvar r = 0; r < NUM_REGS; r++) begin : g_chk
      // R2: plain write replaces the mask
      p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && hit[r] && mode == ACC_WRITE) |=> (regs_q[r] == $past(wdata)));
      // R3: set alias only raises written ones
      p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && hit[r] && mode == ACC_SET) |=>
            (((regs_q[r] & $past(wdata)) == $past(wdata)) &&
             ((regs_q[r] & ~$past(wdata)) == ($past(regs_q[r]) & ~$past(wdata)))));
      // R4: clear alias only drops written ones
      p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && hit[r] && mode == ACC_CLEAR) |=>
            (((regs_q[r] & $past(wdata)) == '0) &&
             ((regs_q[r] & ~$past(wdata)) == ($past(regs_q[r]) & ~$past(wdata)))));
      // R11: untargeted registers hold their value
      p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
         !(wr_en && hit[r]) |=> $stable(regs_q[r]));
   end
endmodule

// File: rtl/pinmux_prio_decode.sv
module pinmux_prio_decode #(
   parameter int NUM_PINS  = 32,
   parameter int NUM_FUNCS = 5,
   parameter int CODE_W    = 3
) (
   input  logic [NUM_FUNCS-1:0][NUM_PINS-1:0] sel_mask,
   output logic [NUM_PINS-1:0][CODE_W-1:0]    code
);
   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic [CODE_W-1:0] c;
      always_comb begin
         c = '0;
         // walk from lowest priority upward so the highest-priority claim is last to write
         for (int f = NUM_FUNCS - 1; f >= 0; f--)
            if (sel_mask[f][p]) c = CODE_W'(f + 1);
      end
      assign code[p] = c;
   end
endmodule

// File: rtl/pinmux_pad_route.sv
module pinmux_pad_route #(
   parameter int NUM_PINS     = 32,
   parameter int NUM_FUNCS    = 5,
   parameter int CODE_W       = 3,
   parameter bit ONEHOT_ROUTE = 1'b1
) (
   input  logic [NUM_PINS-1:0][CODE_W-1:0]    code,
   input  logic [NUM_PINS-1:0]                gpio_out,
   input  logic [NUM_PINS-1:0]                gpio_oe,
   input  logic [NUM_FUNCS-1:0][NUM_PINS-1:0] func_out,
   input  logic [NUM_FUNCS-1:0][NUM_PINS-1:0] func_oe,
   output logic [NUM_PINS-1:0]                pad_out,
   output logic [NUM_PINS-1:0]                pad_oe
);
   localparam int NUM_SRC = NUM_FUNCS + 1;

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic [NUM_SRC-1:0] src_o;
      logic [NUM_SRC-1:0] src_e;

      always_comb begin
         src_o[0] = gpio_out[p];
         src_e[0] = gpio_oe[p];
         for (int f = 0; f < NUM_FUNCS; f++) begin
            src_o[f+1] = func_out[f][p];
            src_e[f+1] = func_oe[f][p];
         end
      end

      if (ONEHOT_ROUTE) begin : g_andor
         logic [NUM_SRC-1:0] sel_1h;
         assign sel_1h     = NUM_SRC'(1) << code[p];
         assign pad_out[p] = |(src_o & sel_1h);
         assign pad_oe[p]  = |(src_e & sel_1h);
      end else begin : g_index
         assign pad_out[p] = src_o[code[p]];
         assign pad_oe[p]  = src_e[code[p]];
      end
   end
endmodule

// File: rtl/pinmux_bank.sv
module pinmux_bank
   import pinmux_pkg::*;
#(
   parameter int NUM_PINS     = 32,
   parameter int NUM_FUNCS    = 5,
   parameter int ADDR_W       = 10,
   parameter bit ONEHOT_ROUTE = 1'b1,
   localparam int CODE_W      = $clog2(NUM_FUNCS + 1)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          reg_wr,
   input  logic [ADDR_W-1:0]             reg_addr,
   input  logic [NUM_PINS-1:0]           reg_wdata,
   output logic [NUM_PINS-1:0]           reg_rdata,
   input  logic [NUM_PINS-1:0]           gpio_out,
   input  logic [NUM_PINS-1:0]           gpio_oe,
   output logic [NUM_PINS-1:0]           gpio_in,
   input  logic [NUM_FUNCS*NUM_PINS-1:0] func_out,
   input  logic [NUM_FUNCS*NUM_PINS-1:0] func_oe,
   output logic [NUM_FUNCS*NUM_PINS-1:0] func_in,
   output logic [NUM_PINS-1:0]           pad_out,
   output logic [NUM_PINS-1:0]           pad_oe,
   input  logic [NUM_PINS-1:0]           pad_in,
   output logic [NUM_PINS-1:0]           pad_pull_up,
   output logic [NUM_PINS*CODE_W-1:0]    pin_code
);
   if (NUM_FUNCS != NUM_SEL) begin : g_bad_funcs
      $error("pinmux_bank: NUM_FUNCS must match the offset table size");
   end
   if (ADDR_W != OFS_W + ACC_W) begin : g_bad_addr
      $error("pinmux_bank: ADDR_W must equal offset plus access bits");
   end
   if (NUM_PINS < 1) begin : g_bad_pins
      $error("pinmux_bank: NUM_PINS must be positive");
   end

   logic [NUM_FUNCS-1:0][NUM_PINS-1:0] sel_mask;
   logic [NUM_FUNCS-1:0][NUM_PINS-1:0] fo;
   logic [NUM_FUNCS-1:0][NUM_PINS-1:0] fe;
   logic [NUM_PINS-1:0][CODE_W-1:0]    code;

   assign fo = func_out;
   assign fe = func_oe;

   pinmux_sel_regs #(
      .NUM_PINS (NUM_PINS),
      .NUM_FUNCS(NUM_FUNCS),
      .ADDR_W   (ADDR_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr),
      .addr     (reg_addr),
      .wdata    (reg_wdata),
      .rdata    (reg_rdata),
      .sel_mask (sel_mask),
      .pull_mask(pad_pull_up)
   );

   pinmux_prio_decode #(
      .NUM_PINS (NUM_PINS),
      .NUM_FUNCS(NUM_FUNCS),
      .CODE_W   (CODE_W)
   ) u_decode (
      .sel_mask(sel_mask),
      .code    (code)
   );

   pinmux_pad_route #(
      .NUM_PINS    (NUM_PINS),
      .NUM_FUNCS   (NUM_FUNCS),
      .CODE_W      (CODE_W),
      .ONEHOT_ROUTE(ONEHOT_ROUTE)
   ) u_route (
      .code    (code),
      .gpio_out(gpio_out),
      .gpio_oe (gpio_oe),
      .func_out(fo),
      .func_oe (fe),
      .pad_out (pad_out),
      .pad_oe  (pad_oe)
   );

   assign gpio_in  = pad_in;
   assign func_in  = {NUM_FUNCS{pad_in}};
   assign pin_code = code;

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
      // R5: a claim by function 1 always wins
      p_top_prio_r5: assert property (@(posedge clk) disable iff (!rst_n)
         sel_mask[0][p] |-> (code[p] == CODE_W'(1)));
      // R6: unclaimed pin is driven by GPIO
      p_gpio_owns_r6: assert property (@(posedge clk) disable iff (!rst_n)
         (code[p] == '0) |-> ((pad_out[p] == gpio_out[p]) && (pad_oe[p] == gpio_oe[p])));
      // R7: claimed pin follows its owner only
      p_func_drives_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (code[p] != '0) |->
            ((pad_out[p] == fo[code[p] - 1'b1][p]) && (pad_oe[p] == fe[code[p] - 1'b1][p])));
      // R9: code never names a missing function
      p_code_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
         code[p] <= CODE_W'(NUM_FUNCS));
   end
endmodule

// File: tb/pinmux_bank_tb.sv
`timescale 1ns/1ps
module pinmux_bank_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_wr = 1'b0;
   logic [9:0]   reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic [31:0]  gpio_out, gpio_oe, gpio_in;
   logic [159:0] func_out, func_oe, func_in;
   logic [31:0]  pad_out, pad_oe, pad_in, pad_pull_up;
   logic [95:0]  pin_code;

   always #2.5 clk = ~clk;

   pinmux_bank u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .gpio_out(gpio_out),
      .gpio_oe(gpio_oe), .gpio_in(gpio_in), .func_out(func_out),
      .func_oe(func_oe), .func_in(func_in), .pad_out(pad_out), .pad_oe(pad_oe),
      .pad_in(pad_in), .pad_pull_up(pad_pull_up), .pin_code(pin_code)
   );

   // scoreboard queues
   int           q_sel[$];
   logic [159:0] q_exp[$];
   string        q_tag[$];
   event         chk_ev;
   int           n_run = 0, n_fail = 0;
   bit           done = 0;
   int           m_sel;
   logic [159:0] m_exp, m_act;
   string        m_tag;

   logic [31:0]  mdl[6];

   function automatic logic [7:0] bench_ofs(int r);
      case (r)
         0: return 8'h14; 1: return 8'h8C; 2: return 8'h94;
         3: return 8'h9C; 4: return 8'hA4; default: return 8'hAC;
      endcase
   endfunction

   function automatic logic [159:0] sample(int sel);
      case (sel)
         0: return 160'(pad_out);
         1: return 160'(pad_oe);
         2: return 160'(pin_code);
         3: return 160'(reg_rdata);
         4: return 160'(gpio_in);
         5: return func_in;
         default: return 160'(pad_pull_up);
      endcase
   endfunction

   // monitor
   initial begin
      forever begin
         @(chk_ev);
         while (q_sel.size() > 0) begin
            m_sel = q_sel.pop_front();
            m_exp = q_exp.pop_front();
            m_tag = q_tag.pop_front();
            m_act = sample(m_sel);
            n_run++;
            if (m_act !== m_exp) begin
               n_fail++;
               $display("FAIL %s (item %0d): act=%h exp=%h", m_tag, m_sel, m_act, m_exp);
            end
         end
      end
   end

   task automatic push(int sel, logic [159:0] exp, string tag);
      q_sel.push_back(sel);
      q_exp.push_back(exp);
      q_tag.push_back(tag);
      -> chk_ev;
      #0.5;
   endtask

   function automatic logic [2:0] exp_code(int p);
      for (int f = 0; f < 5; f++)
         if (mdl[f][p]) return 3'(f + 1);
      return 3'd0;
   endfunction

   task automatic check_pads(string tag);
      logic [31:0] eo, ee;
      logic [95:0] ec;
      for (int p = 0; p < 32; p++) begin
         logic [2:0] c;
         c = exp_code(p);
         ec[3*p +: 3] = c;
         if (c == 3'd0) begin
            eo[p] = gpio_out[p];
            ee[p] = gpio_oe[p];
         end else begin
            eo[p] = func_out[(int'(c) - 1)*32 + p];
            ee[p] = func_oe[(int'(c) - 1)*32 + p];
         end
      end
      push(0, 160'(eo), {tag, " pad_out"});
      push(1, 160'(ee), {tag, " pad_oe"});
      push(2, 160'(ec), {tag, " pin_code"});
   endtask

   function automatic logic [31:0] model_rd(logic [9:0] a);
      if (a[9:8] == 2'b11) return '0;
      for (int r = 0; r < 6; r++)
         if (a[7:0] == bench_ofs(r)) return mdl[r];
      return '0;
   endfunction

   task automatic wr(logic [9:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      if (a[9:8] != 2'b11)
         for (int r = 0; r < 6; r++)
            if (a[7:0] == bench_ofs(r))
               case (a[9:8])
                  2'b00: mdl[r] = d;
                  2'b01: mdl[r] = mdl[r] | d;
                  default: mdl[r] = mdl[r] & ~d;
               endcase
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [9:0] a, string tag);
      reg_addr = a;
      #0.5;
      push(3, 160'(model_rd(a)), tag);
   endtask

   // watchdog
   initial begin
      #200000;
      if (!done) begin
         n_fail++;
         $display("FAIL all: watchdog act=running exp=finished");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      for (int r = 0; r < 6; r++) mdl[r] = '0;
      gpio_out = 32'hA5A5_5A5A;
      gpio_oe  = 32'hFFFF_0000;
      func_out = {32'hCCCC_CCCC, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 32'h0000_0000, 32'hFFFF_FFFF};
      func_oe  = {32'h5555_5555, 32'hAAAA_AAAA, 32'h0000_FFFF, 32'hFFFF_FFFF, 32'h3333_3333};
      pad_in   = 32'h0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #0.5;

      // R1: reset state
      check_pads("R1");
      for (int r = 0; r < 6; r++) rd({2'b00, bench_ofs(r)}, "R1 reset read");

      // R2: plain writes and readback, R9 code layout
      wr(10'h014, 32'h0000_00FF);
      wr(10'h08C, 32'h0000_FF0F);
      wr(10'h094, 32'h00FF_0F00);
      wr(10'h09C, 32'hFF0F_0000);
      wr(10'h0A4, 32'h0F00_00F0);
      for (int r = 0; r < 5; r++) rd({2'b00, bench_ofs(r)}, "R2 readback");
      rd(10'h114, "R2 set-alias read");
      rd(10'h28C, "R2 clear-alias read");
      check_pads("R9 mixed claims");

      // R7: GPIO changes do not reach claimed pins
      gpio_out = ~gpio_out;
      gpio_oe  = ~gpio_oe;
      check_pads("R7 gpio change");
      func_out[64 +: 32] = 32'h1234_ABCD;
      check_pads("R7 owner change");

      // R3: set alias
      wr(10'h114, 32'h0000_0F00);
      rd(10'h014, "R3 set");
      check_pads("R3");
      // R4: clear alias
      wr(10'h28C, 32'h0000_000F);
      rd(10'h08C, "R4 clear");
      check_pads("R4");

      // R5: priority ladder on pin 31
      for (int r = 0; r < 5; r++) wr({2'b01, bench_ofs(r)}, 32'h8000_0000);
      check_pads("R5 all claim");
      for (int r = 0; r < 5; r++) begin
         wr({2'b10, bench_ofs(r)}, 32'h8000_0000);
         check_pads("R5 ladder");
      end

      // R6: everything back to GPIO
      for (int r = 0; r < 5; r++) wr({2'b00, bench_ofs(r)}, 32'h0);
      check_pads("R6 all gpio");

      // R8: input fan-out under a function claim
      wr(10'h09C, 32'hFFFF_FFFF);
      pad_in = 32'h1234_5678;
      #0.5;
      push(4, 160'(32'h1234_5678), "R8 gpio_in");
      push(5, {5{32'h1234_5678}}, "R8 func_in");
      pad_in = 32'hEDCB_A987;
      #0.5;
      push(4, 160'(32'hEDCB_A987), "R8 gpio_in");
      push(5, {5{32'hEDCB_A987}}, "R8 func_in");

      // R10: pull-up mask
      wr(10'h0AC, 32'h0000_F00F);
      push(6, 160'(32'h0000_F00F), "R10 write");
      wr(10'h1AC, 32'hF000_0000);
      push(6, 160'(32'hF000_F00F), "R10 set");
      wr(10'h2AC, 32'h0000_000F);
      push(6, 160'(32'hF000_F000), "R10 clear");
      rd(10'h0AC, "R10 read");
      check_pads("R10 no effect on select");

      // R11: ignored writes, zero reads
      wr(10'h314, 32'hFFFF_FFFF);
      rd(10'h014, "R11 access 11 write");
      wr(10'h040, 32'hFFFF_FFFF);
      rd(10'h040, "R11 unmapped read");
      rd(10'h39C, "R11 access 11 read");
      check_pads("R11");

      done = 1;
      #2;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule